// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer Pair

This block holds two independent timers and one shared interrupt unit. Each timer divides the system clock by a programmable 16-bit prescaler. Each prescaler tick moves a 64-bit count one step up or down. A 64-bit compare value can raise an alarm. The alarm is one-shot and, if selected, reloads the count from a staged load value. Software reads the count coherently by strobing a snapshot, which copies all 64 bits in one cycle into two 32-bit read words.

The interrupt unit gathers one alarm bit per timer. It offers a sticky raw word, an enable mask, a masked status word and a write-one-to-clear word. Each timer drives a level interrupt line and a single-cycle edge interrupt line.

The register port is a plain synchronous write strobe with a combinational read. The 6-bit word address is {sel[1:0], idx[3:0]}: sel 0 and 1 pick a timer, sel 2 picks the interrupt unit. The snapshot logic is a two-state machine. In state SNAP_IDLE it waits, and an update write takes it to SNAP_BUSY (transition "strobe"). In SNAP_BUSY it copies the count and returns to SNAP_IDLE on the next clock (transition "copy done").

Top module: `tmr_group`

## Requirements
- R1: The divider field is config word (idx 0) bits [31:16]. Code 0 divides by 65536, code 1 divides by 2, and any other code N divides by N. With the timer enabled, the count steps on the clock edges that are N, 2N, 3N, ... edges after the edge that wrote the config word.
- R2: The load value is staged in idx 4 (low half) and idx 5 (high half). Writing those words leaves the count untouched. A write to idx 6 copies the full 64-bit load value into the count at that edge.
- R3: A write to idx 3 enters SNAP_BUSY. While the machine is busy, idx 3 bit 0 reads 1. One edge later the count is copied to idx 1 (low half) and idx 2 (high half), and bit 0 reads 0 again.
- R4: Config bit 1 selects the direction: 1 counts up and 0 counts down. The count wraps modulo 2^64, and carries and borrows cross the 32-bit halves.
- R5: Config bit 0 enables counting. While it is 0, the count holds its value apart from explicit reloads.
- R6: The alarm compare is written at idx 7 (low half) and idx 8 (high half). While config bit 3 (alarm arm) is set and the count equals the compare, the timer's raw interrupt bit is set. While bit 3 is clear, no raw bit is set.
- R7: When config bit 2 is set, an alarm match reloads the count from the load value on the following edge, and the prescaler phase is left as it was.
- R8: An alarm match clears config bit 3 on the following edge, so the alarm does not fire again until software re-arms it.
- R9: The interrupt unit is at sel 2 and has four words: raw at idx 0, enable at idx 1, status (raw AND enable) at idx 2 and clear at idx 3. Bit t belongs to timer t and all other bits read 0. Raw bits stay set until a 1 is written to the matching bit of the clear word.
- R10: The level output of timer t is high while its status bit is set and its config bit 4 is set.
- R11: The edge output of timer t pulses for exactly one cycle. The pulse comes one edge after an alarm match, and only while config bit 5 and enable bit t are both set.
- R12: Any write to a timer's config word restarts that timer's prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address {sel, idx} |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| irq_level | output | 2 | Level interrupt per timer |
| irq_edge | output | 2 | One-cycle edge interrupt per timer |

## Verification
The assertions assume one register access per cycle and no update write while a snapshot is already in SNAP_BUSY. They also assume software does not re-arm an alarm in the same cycle an edge pulse is issued. The stimulus writes one word per clock from the falling edge. It waits a full cycle after each update strobe before reading the snapshot. It programs the compare and load words only while the timer concerned is disabled, so every count it predicts follows from whole tick intervals since the last config write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int DW     = 32;
    parameter int DIV_W  = 16;
    parameter int N_TMR  = 2;
    parameter int SEL_W  = 2;
    parameter int IDX_W  = 4;
    localparam int CNT_W = 2 * DW;
    localparam logic [SEL_W-1:0] SEL_IRQ = SEL_W'(N_TMR);

    // timer word indices
    localparam logic [IDX_W-1:0] IX_CFG    = 4'd0;
    localparam logic [IDX_W-1:0] IX_SNAPLO = 4'd1;
    localparam logic [IDX_W-1:0] IX_SNAPHI = 4'd2;
    localparam logic [IDX_W-1:0] IX_UPD    = 4'd3;
    localparam logic [IDX_W-1:0] IX_LDLO   = 4'd4;
    localparam logic [IDX_W-1:0] IX_LDHI   = 4'd5;
    localparam logic [IDX_W-1:0] IX_RELOAD = 4'd6;
    localparam logic [IDX_W-1:0] IX_ALLO   = 4'd7;
    localparam logic [IDX_W-1:0] IX_ALHI   = 4'd8;

    // interrupt unit word indices
    localparam logic [IDX_W-1:0] IX_RAW  = 4'd0;
    localparam logic [IDX_W-1:0] IX_ENA  = 4'd1;
    localparam logic [IDX_W-1:0] IX_STAT = 4'd2;
    localparam logic [IDX_W-1:0] IX_CLR  = 4'd3;

    typedef enum logic {SNAP_IDLE = 1'b0, SNAP_BUSY = 1'b1} snap_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] term;

    // terminal phase = divide ratio - 1
    always_comb begin
        if (div_code == '0)
            term = '1;
        else if (div_code == DIV_W'(1))
            term = DIV_W'(1);
        else
            term = div_code - DIV_W'(1);
    end

    assign tick = run && (cnt_q == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (run)
            cnt_q <= (cnt_q == term) ? '0 : cnt_q + DIV_W'(1);
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd,
    output logic             alarm_evt,
    output logic             lvl_ie,
    output logic             edg_ie
);
    logic             en_q, up_q, arl_q, alm_q, lvl_q, edg_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] load_q, cmp_q, count_q, snap_q;
    logic             tick;
    snap_state_e      state_q, state_d;

    logic wr_cfg, wr_upd, wr_reload;
    assign wr_cfg    = wr && (idx == IX_CFG);
    assign wr_upd    = wr && (idx == IX_UPD);
    assign wr_reload = wr && (idx == IX_RELOAD);

    assign alarm_evt = alm_q && (count_q == cmp_q);
    assign lvl_ie    = lvl_q;
    assign edg_ie    = edg_q;

    tmr_prescaler u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .restart  (wr_cfg),
        .div_code (div_q),
        .tick     (tick)
    );

    // configuration word; a match disarms the alarm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {en_q, up_q, arl_q, alm_q, lvl_q, edg_q} <= '0;
            div_q <= '0;
        end else if (wr_cfg) begin
            en_q  <= wdata[0];
            up_q  <= wdata[1];
            arl_q <= wdata[2];
            alm_q <= wdata[3];
            lvl_q <= wdata[4];
            edg_q <= wdata[5];
            div_q <= wdata[DW-1 -: DIV_W];
        end else if (alarm_evt) begin
            alm_q <= 1'b0;
        end
    end

    // staged load and compare halves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            cmp_q  <= '0;
        end else if (wr) begin
            if (idx == IX_LDLO) load_q[DW-1:0]     <= wdata;
            if (idx == IX_LDHI) load_q[CNT_W-1:DW] <= wdata;
            if (idx == IX_ALLO) cmp_q[DW-1:0]      <= wdata;
            if (idx == IX_ALHI) cmp_q[CNT_W-1:DW]  <= wdata;
        end
    end

    // time base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (wr_reload || (alarm_evt && arl_q))
            count_q <= load_q;
        else if (tick)
            count_q <= up_q ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
    end

    // snapshot machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE: if (wr_upd) state_d = SNAP_BUSY;
            SNAP_BUSY: state_d = SNAP_IDLE;
        endcase
    end

    // snapshot machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap_q <= '0;
        else if (state_q == SNAP_BUSY)
            snap_q <= count_q;
    end

    always_comb begin
        unique case (idx)
            IX_CFG:    rd = {div_q, {(DW-DIV_W-6){1'b0}}, edg_q, lvl_q, alm_q, arl_q, up_q, en_q};
            IX_SNAPLO: rd = snap_q[DW-1:0];
            IX_SNAPHI: rd = snap_q[CNT_W-1:DW];
            IX_UPD:    rd = {{(DW-1){1'b0}}, state_q == SNAP_BUSY};
            IX_LDLO:   rd = load_q[DW-1:0];
            IX_LDHI:   rd = load_q[CNT_W-1:DW];
            IX_ALLO:   rd = cmp_q[DW-1:0];
            IX_ALHI:   rd = cmp_q[CNT_W-1:DW];
            default:   rd = '0;
        endcase
    end

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> (count_q == $past(load_q)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_reload && !(alarm_evt && arl_q)) |=> $stable(count_q));
    p_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_BUSY) |=> ((state_q == SNAP_IDLE) && (snap_q == $past(count_q))));
    p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && !wr_cfg) |=> !alm_q);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [N_TMR-1:0] wbits,
    input  logic [N_TMR-1:0] evt,
    input  logic [N_TMR-1:0] lvl_ie,
    input  logic [N_TMR-1:0] edg_ie,
    output logic [DW-1:0]    rd,
    output logic [N_TMR-1:0] irq_level,
    output logic [N_TMR-1:0] irq_edge
);
    logic [N_TMR-1:0] raw_q, ena_q, edge_q, clr_mask;

    assign clr_mask = (wr && (idx == IX_CLR)) ? wbits : '0;

    // new events win over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            ena_q  <= '0;
            edge_q <= '0;
        end else begin
            raw_q  <= (raw_q & ~clr_mask) | evt;
            edge_q <= evt & edg_ie & ena_q;
            if (wr && (idx == IX_ENA)) ena_q <= wbits;
        end
    end

    assign irq_level = raw_q & ena_q & lvl_ie;
    assign irq_edge  = edge_q;

    always_comb begin
        unique case (idx)
            IX_RAW:  rd = {{(DW-N_TMR){1'b0}}, raw_q};
            IX_ENA:  rd = {{(DW-N_TMR){1'b0}}, ena_q};
            IX_STAT: rd = {{(DW-N_TMR){1'b0}}, raw_q & ena_q};
            default: rd = '0;
        endcase
    end

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W+IDX_W-1:0] addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rd_data,
    output logic [N_TMR-1:0]       irq_level,
    output logic [N_TMR-1:0]       irq_edge
);
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] idx;
    assign sel = addr[SEL_W+IDX_W-1:IDX_W];
    assign idx = addr[IDX_W-1:0];

    logic [DW-1:0]    rd_ch [N_TMR];
    logic [DW-1:0]    rd_irq;
    logic [N_TMR-1:0] evt, lvl_ie, edg_ie;

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        tmr_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_en && (sel == SEL_W'(t))),
            .idx       (idx),
            .wdata     (wdata),
            .rd        (rd_ch[t]),
            .alarm_evt (evt[t]),
            .lvl_ie    (lvl_ie[t]),
            .edg_ie    (edg_ie[t])
        );
    end

    tmr_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_en && (sel == SEL_IRQ)),
        .idx       (idx),
        .wbits     (wdata[N_TMR-1:0]),
        .evt       (evt),
        .lvl_ie    (lvl_ie),
        .edg_ie    (edg_ie),
        .rd        (rd_irq),
        .irq_level (irq_level),
        .irq_edge  (irq_edge)
    );

    always_comb begin
        rd_data = '0;
        if (sel == SEL_IRQ) rd_data = rd_irq;
        for (int t = 0; t < N_TMR; t++)
            if (sel == SEL_W'(t)) rd_data = rd_ch[t];
    end
endmodule

// File: tb/tmr_group_tb.sv
module tmr_group_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  irq_level, irq_edge;

    int n_chk = 0;
    int n_bad = 0;
    int e0 = 0;
    int e1 = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_group dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .irq_level(irq_level), .irq_edge(irq_edge)
    );

    always @(negedge clk) if (rst_n) begin
        if (irq_edge[0]) e0++;
        if (irq_edge[1]) e1++;
    end

    localparam logic [3:0] I_CFG = 0, I_SLO = 1, I_SHI = 2, I_UPD = 3, I_LLO = 4,
                           I_LHI = 5, I_RLD = 6, I_ALO = 7, I_AHI = 8;
    localparam logic [5:0] Q_RAW = 6'h20, Q_ENA = 6'h21, Q_STAT = 6'h22, Q_CLR = 6'h23;

    typedef struct packed {
        logic [63:0] ld;
        logic        up;
        logic [15:0] dv;
        logic [31:0] w;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{64'h0,                   1'b1, 16'd2, 32'd9, 64'h5},
        '{64'hFFFF_FFFF,           1'b1, 16'd3, 32'd8, 64'h1_0000_0002},
        '{64'h1_0000_0001,         1'b0, 16'd2, 32'd5, 64'hFFFF_FFFE},
        '{64'h5,                   1'b0, 16'd1, 32'd7, 64'h1},
        '{64'h0,                   1'b0, 16'd4, 32'd7, 64'hFFFF_FFFF_FFFF_FFFE},
        '{64'h1234_5678_9ABC_DEF0, 1'b1, 16'd5, 32'd9, 64'h1234_5678_9ABC_DEF2}
    };

    function automatic logic [31:0] cfg(input logic en, up, arl, alm, lvl, edg, input logic [15:0] dv);
        return {dv, 10'b0, edg, lvl, alm, arl, up, en};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a; #1; d = rd_data;
    endtask

    function automatic logic [5:0] ta(input int t, input logic [3:0] i);
        return {t[1:0], i};
    endfunction

    task automatic load(input int t, input logic [63:0] v);
        wr(ta(t, I_LLO), v[31:0]);
        wr(ta(t, I_LHI), v[63:32]);
        wr(ta(t, I_RLD), 32'h0);
    endtask

    task automatic snap(input int t, output logic [63:0] v);
        logic [31:0] lo, hi;
        wr(ta(t, I_UPD), 32'h1);
        @(negedge clk);
        rd(ta(t, I_SLO), lo);
        rd(ta(t, I_SHI), hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(ta(0, I_CFG), d);  chk(d == 0, "reset cfg R5", d, 0);
        rd(ta(0, I_UPD), d);  chk(d == 0, "reset update R3", d, 0);
        rd(ta(1, I_SLO), d);  chk(d == 0, "reset snapshot R3", d, 0);
        rd(Q_RAW, d);         chk(d == 0, "reset raw R9", d, 0);
        chk(irq_level == 0 && irq_edge == 0, "reset irq R10", {irq_level, irq_edge}, 0);

        // table walk: direction R4, divider R1, enable R5
        foreach (VECS[i]) begin
            load(0, VECS[i].ld);
            wr(ta(0, I_CFG), cfg(1, VECS[i].up, 0, 0, 0, 0, VECS[i].dv));
            repeat (VECS[i].w) @(negedge clk);
            wr(ta(0, I_CFG), cfg(0, VECS[i].up, 0, 0, 0, 0, VECS[i].dv));
            snap(0, v);
            chk(v == VECS[i].exp, $sformatf("vector %0d count R1 R4", i), v, VECS[i].exp);
        end
        rd(Q_RAW, d); chk(d == 0, "unarmed alarm raises nothing R6", d, 0);

        // hold while disabled R5
        repeat (20) @(negedge clk);
        snap(0, v); chk(v == VECS[5].exp, "disabled count holds R5", v, VECS[5].exp);

        // staged load R2
        wr(ta(0, I_LLO), 32'hAAAA_5555);
        wr(ta(0, I_LHI), 32'h0F0F_F0F0);
        snap(0, v); chk(v == VECS[5].exp, "halves alone leave count R2", v, VECS[5].exp);
        wr(ta(0, I_RLD), 32'h0);
        snap(0, v); chk(v == 64'h0F0F_F0F0_AAAA_5555, "reload strobe R2", v, 64'h0F0F_F0F0_AAAA_5555);

        // update busy bit R3
        wr(ta(0, I_UPD), 32'h1);
        rd(ta(0, I_UPD), d); chk(d == 1, "update bit busy R3", d, 1);
        @(negedge clk);
        rd(ta(0, I_UPD), d); chk(d == 0, "update bit clears R3", d, 0);

        // prescaler restart on config write R12
        load(0, 64'h0);
        wr(ta(0, I_CFG), cfg(1, 1, 0, 0, 0, 0, 16'd4));
        @(negedge clk);
        wr(ta(0, I_CFG), cfg(1, 1, 0, 0, 0, 0, 16'd4));
        repeat (2) @(negedge clk);
        wr(ta(0, I_CFG), cfg(0, 1, 0, 0, 0, 0, 16'd4));
        snap(0, v); chk(v == 0, "config write restarts phase R12", v, 0);

        // alarm with auto-reload on timer 0
        load(0, 64'h0);
        wr(ta(0, I_ALO), 32'd3);
        wr(ta(0, I_AHI), 32'd0);
        wr(Q_ENA, 32'h1);
        e0 = 0;
        wr(ta(0, I_CFG), cfg(1, 1, 1, 1, 1, 1, 16'd2));
        repeat (11) @(negedge clk);
        wr(ta(0, I_CFG), cfg(0, 1, 1, 0, 1, 1, 16'd2));
        snap(0, v); chk(v == 3, "auto-reload restarts count R7", v, 3);
        chk(e0 == 1, "single edge pulse R11", e0, 1);
        rd(Q_RAW, d);  chk(d == 1, "raw set on match R6", d, 1);
        rd(Q_STAT, d); chk(d == 1, "status masked R9", d, 1);
        chk(irq_level[0] == 1'b1, "level follows status R10", irq_level, 1);
        wr(Q_CLR, 32'h2);
        rd(Q_RAW, d);  chk(d == 1, "clear of other bit ignored R9", d, 1);
        wr(Q_CLR, 32'h1);
        rd(Q_RAW, d);  chk(d == 0, "write-one clears raw R9", d, 0);
        chk(irq_level[0] == 1'b0, "level drops after clear R10", irq_level, 0);
        repeat (5) @(negedge clk);
        rd(Q_RAW, d);  chk(d == 0, "disarmed alarm stays quiet R8", d, 0);
        rd(ta(0, I_CFG), d); chk(d[3] == 1'b0, "arm bit self-clears R8", d, 0);

        // masked alarm on timer 1, no auto-reload
        load(1, 64'd10);
        wr(ta(1, I_ALO), 32'd8);
        wr(ta(1, I_AHI), 32'd0);
        e1 = 0;
        wr(ta(1, I_CFG), cfg(1, 0, 0, 1, 1, 1, 16'd2));
        repeat (7) @(negedge clk);
        wr(ta(1, I_CFG), cfg(0, 0, 0, 0, 1, 1, 16'd2));
        snap(1, v); chk(v == 6, "no reload without auto bit R7", v, 6);
        rd(Q_RAW, d);  chk(d == 2, "timer 1 raw bit R6", d, 2);
        rd(Q_STAT, d); chk(d == 0, "masked status R9", d, 0);
        chk(irq_level[1] == 1'b0 && e1 == 0, "masked lines silent R10 R11", {irq_level, e1[1:0]}, 0);
        wr(Q_ENA, 32'h3);
        rd(Q_STAT, d); chk(d == 2, "status after enable R9", d, 2);
        chk(irq_level[1] == 1'b1, "level after enable R10", irq_level, 2);
        wr(Q_ENA, 32'hFFFF_FFFF);
        rd(Q_ENA, d);  chk(d == 3, "upper enable bits read zero R9", d, 3);
        wr(Q_CLR, 32'h3);

        // divider code 0 means 65536 R1
        load(1, 64'h0);
        wr(ta(1, I_CFG), cfg(1, 1, 0, 0, 0, 0, 16'd0));
        repeat (65534) @(negedge clk);
        wr(ta(1, I_CFG), cfg(0, 1, 0, 0, 0, 0, 16'd0));
        snap(1, v); chk(v == 0, "code 0 before 65536 edges R1", v, 0);
        wr(ta(1, I_CFG), cfg(1, 1, 0, 0, 0, 0, 16'd0));
        repeat (65535) @(negedge clk);
        wr(ta(1, I_CFG), cfg(0, 1, 0, 0, 0, 0, 16'd0));
        snap(1, v); chk(v == 1, "code 0 at 65536 edges R1", v, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule